// File: doc/BRIEF.md
# Dual-Access Power Event Status Registers

This block holds a one-byte power event status register and two one-byte enable registers. Two masters share them: a host register port and an embedded microcontroller port. The microcontroller drives each status bit directly, so firmware can present power-button, sleep-button, clock-alarm, button-override and wake events as if hardware had raised them. The host can only acknowledge an event, by writing a one to the bit it wants cleared.

Every host write to the status register raises a sticky interrupt request toward the microcontroller. That request stays up until firmware pulses a dedicated clear strobe. The first enable register is a placeholder that always reads as zero. The second is an ordinary read/write byte, reachable from both ports.

Both ports are simple synchronous register interfaces. Each has an address, a write strobe, a read strobe, write data and registered read data. One synchronous active-high power-on reset initialises the whole bank.

Top module: `pm_evt_regs`

## Requirements
- R1: Status bit layout: bit 0 power button, bit 1 sleep button, bit 2 clock alarm, bit 3 button override, bit 7 wake. The host reads the status byte at offset 1 and the microcontroller reads it at address 0.
- R2: Status bits 4, 5 and 6 read as zero on both ports, whatever value was written to them.
- R3: A microcontroller write to address 0 loads every implemented status bit from the write data. A one sets the bit and a zero clears it.
- R4: A host write to offset 1 clears each implemented status bit whose write data bit is one. Bits written with zero keep their value.
- R5: Any host write to offset 1 drives `mcu_irq` high from the next cycle on.
- R6: `mcu_irq` stays high until a cycle with `mcu_irq_clr` high, and then drops in the next cycle. When a host status write and the clear strobe arrive in the same cycle, the request stays set.
- R7: Host offset 2 (first enable register) and host offset 0 always read 00h. Writes to either offset change no register and raise no interrupt.
- R8: The second enable register sits at host offset 3 and at microcontroller address 1. Either port overwrites it. Only the bits in `EN2_MASK` (default 07h) are kept, and the rest read zero. When both ports write it in the same cycle, the host value is kept.
- R9: When both ports write the status register in the same cycle, the microcontroller value is loaded first and the host clear mask is then applied on top of it.
- R10: Reset clears the status byte, both enable registers, both read data outputs and `mcu_irq`.
- R11: Read data appears one cycle after the read strobe and carries the register value from the strobe cycle, before any write in that same cycle takes effect. It holds until the next read strobe on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| host_addr | input | 2 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host registered read data |
| mcu_addr | input | 1 | Microcontroller register address |
| mcu_wr | input | 1 | Microcontroller write strobe |
| mcu_rd | input | 1 | Microcontroller read strobe |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Microcontroller registered read data |
| mcu_irq_clr | input | 1 | Interrupt acknowledge strobe |
| mcu_irq | output | 1 | Sticky interrupt request to the microcontroller |

## Verification
Every result of this block is due exactly one cycle after the stimulus that causes it:
- A register written in cycle N shows in read data for a read strobed in cycle N+1, and that data appears in cycle N+2.
- Read data for a strobe in cycle N appears in cycle N+1.
- `mcu_irq` changes in the cycle after a host status write or a clear strobe.

The driver issues one operation per clock. For each operation it queues the expected values of both read data outputs and of `mcu_irq`, each tagged with the number of the next rising edge. The monitor samples 2 ns after every rising edge and compares only the entries due at that edge. Because of this, the hold behaviour between reads is checked in every cycle as well.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int DW = 8;

    // Implemented status bits: 0..3 and 7
    localparam logic [DW-1:0] STAT_IMPL = 8'h8F;

    typedef enum logic [1:0] {
        H_NONE = 2'd0,
        H_STAT = 2'd1,
        H_EN1  = 2'd2,
        H_EN2  = 2'd3
    } host_off_e;

    typedef enum logic {
        M_STAT = 1'b0,
        M_EN2  = 1'b1
    } mcu_off_e;

    typedef struct packed {
        logic          stat_we;
        logic          en_we;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic wr_req_t host_decode(logic wr, logic [1:0] addr, logic [DW-1:0] d);
        wr_req_t r;
        r.stat_we = wr && (host_off_e'(addr) == H_STAT);
        r.en_we   = wr && (host_off_e'(addr) == H_EN2);
        r.data    = d;
        return r;
    endfunction

    function automatic wr_req_t mcu_decode(logic wr, logic addr, logic [DW-1:0] d);
        wr_req_t r;
        r.stat_we = wr && (mcu_off_e'(addr) == M_STAT);
        r.en_we   = wr && (mcu_off_e'(addr) == M_EN2);
        r.data    = d;
        return r;
    endfunction

endpackage

// File: rtl/pm_evt_status.sv
module pm_evt_status
    import pm_evt_pkg::*;
#(
    parameter logic [DW-1:0] IMPL = STAT_IMPL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          m_we,
    input  logic [DW-1:0] m_wd,
    input  logic          h_we,
    input  logic [DW-1:0] h_wd,
    input  logic          irq_clr,
    output logic [DW-1:0] stat_q,
    output logic          irq_q
);

    logic [DW-1:0] stat_nxt;

    // Direct load from the microcontroller first, then the host clear mask
    always_comb begin
        stat_nxt = stat_q;
        if (m_we) begin
            stat_nxt = m_wd;
        end
        if (h_we) begin
            stat_nxt = stat_nxt & ~h_wd;
        end
        stat_nxt = stat_nxt & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_nxt;
        end
    end

    // Sticky request; a new host write beats a simultaneous acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (h_we) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pm_evt_enable.sv
module pm_evt_enable
    import pm_evt_pkg::*;
#(
    parameter logic [DW-1:0] MASK = 8'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          m_we,
    input  logic [DW-1:0] m_wd,
    input  logic          h_we,
    input  logic [DW-1:0] h_wd,
    output logic [DW-1:0] en_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (h_we) begin
            en_q <= h_wd & MASK;
        end else if (m_we) begin
            en_q <= m_wd & MASK;
        end
    end

endmodule

// File: rtl/pm_evt_rdport.sv
module pm_evt_rdport #(
    parameter int NSRC = 2,
    parameter int DW   = 8,
    localparam int AW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd,
    input  logic [AW-1:0]            sel,
    input  logic [NSRC-1:0][DW-1:0]  src,
    output logic [DW-1:0]            rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= src[sel];
        end
    end

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    parameter logic [DW-1:0] EN2_MASK = 8'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          mcu_addr,
    input  logic          mcu_wr,
    input  logic          mcu_rd,
    input  logic [DW-1:0] mcu_wdata,
    output logic [DW-1:0] mcu_rdata,
    input  logic          mcu_irq_clr,
    output logic          mcu_irq
);

    localparam int HSRC = 4;
    localparam int MSRC = 2;

    wr_req_t hreq;
    wr_req_t mreq;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] en2_q;
    logic [HSRC-1:0][DW-1:0] hsrc;
    logic [MSRC-1:0][DW-1:0] msrc;

    assign hreq = host_decode(host_wr, host_addr, host_wdata);
    assign mreq = mcu_decode(mcu_wr, mcu_addr, mcu_wdata);

    pm_evt_status #(.IMPL(STAT_IMPL)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .m_we    (mreq.stat_we),
        .m_wd    (mreq.data),
        .h_we    (hreq.stat_we),
        .h_wd    (hreq.data),
        .irq_clr (mcu_irq_clr),
        .stat_q  (stat_q),
        .irq_q   (mcu_irq)
    );

    pm_evt_enable #(.MASK(EN2_MASK)) u_en2 (
        .clk  (clk),
        .rst  (rst),
        .m_we (mreq.en_we),
        .m_wd (mreq.data),
        .h_we (hreq.en_we),
        .h_wd (hreq.data),
        .en_q (en2_q)
    );

    // Read source maps; the first enable register and offset 0 are constant zero
    always_comb begin
        hsrc         = '0;
        hsrc[H_STAT] = stat_q;
        hsrc[H_EN2]  = en2_q;
        msrc         = '0;
        msrc[M_STAT] = stat_q;
        msrc[M_EN2]  = en2_q;
    end

    pm_evt_rdport #(.NSRC(HSRC), .DW(DW)) u_hrd (
        .clk   (clk),
        .rst   (rst),
        .rd    (host_rd),
        .sel   (host_addr),
        .src   (hsrc),
        .rdata (host_rdata)
    );

    pm_evt_rdport #(.NSRC(MSRC), .DW(DW)) u_mrd (
        .clk   (clk),
        .rst   (rst),
        .rd    (mcu_rd),
        .sel   (mcu_addr),
        .src   (msrc),
        .rdata (mcu_rdata)
    );

endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] host_addr,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       mcu_addr,
    input logic       mcu_wr,
    input logic [7:0] mcu_wdata,
    input logic       mcu_irq_clr,
    input logic       mcu_irq,
    input logic [7:0] stat,
    input logic [7:0] en2
);

    logic h_stat_wr;
    logic m_stat_wr;
    assign h_stat_wr = host_wr && (host_addr == 2'd1);
    assign m_stat_wr = mcu_wr && !mcu_addr;

    AST_MCU_LOAD: assert property (@(posedge clk) disable iff (rst)
        m_stat_wr && !h_stat_wr |=> stat == ($past(mcu_wdata) & 8'h8F)); // R3
    AST_HOST_W1C: assert property (@(posedge clk) disable iff (rst)
        h_stat_wr |=> (stat & $past(host_wdata)) == 8'h00); // R4
    AST_HOST_KEEP: assert property (@(posedge clk) disable iff (rst)
        h_stat_wr && !m_stat_wr |=> ((stat ^ $past(stat)) & ~$past(host_wdata)) == 8'h00); // R4
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        h_stat_wr |=> mcu_irq); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mcu_irq && !mcu_irq_clr |=> mcu_irq); // R6
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
        mcu_irq_clr && !h_stat_wr |=> !mcu_irq); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_addr == 2'd1 |=> host_rdata[6:4] == 3'b000); // R2
    AST_EN1_ZERO: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_addr == 2'd2 |=> host_rdata == 8'h00); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata)); // R11
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> stat == 8'h00 && en2 == 8'h00 && !mcu_irq); // R10

endmodule

bind pm_evt_regs pm_evt_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .mcu_addr    (mcu_addr),
    .mcu_wr      (mcu_wr),
    .mcu_wdata   (mcu_wdata),
    .mcu_irq_clr (mcu_irq_clr),
    .mcu_irq     (mcu_irq),
    .stat        (stat_q),
    .en2         (en2_q)
);

// File: tb/pm_evt_regs_tb.sv
`timescale 1ns/1ps
module pm_evt_regs_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       mcu_addr = 1'b0;
    logic       mcu_wr = 1'b0;
    logic       mcu_rd = 1'b0;
    logic [7:0] mcu_wdata = '0;
    logic [7:0] mcu_rdata;
    logic       mcu_irq_clr = 1'b0;
    logic       mcu_irq;

    always #4 clk = ~clk;

    pm_evt_regs u_dut (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mcu_addr(mcu_addr), .mcu_wr(mcu_wr), .mcu_rd(mcu_rd),
        .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata),
        .mcu_irq_clr(mcu_irq_clr), .mcu_irq(mcu_irq)
    );

    typedef struct {
        int         due;
        int         kind;   // 0 host_rdata, 1 mcu_rdata, 2 mcu_irq
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Reference state, derived from the requirements
    logic [7:0] m_stat = '0;
    logic [7:0] m_en2 = '0;
    logic       m_irq = 1'b0;
    logic [7:0] m_hrd = '0;
    logic [7:0] m_mrd = '0;

    // Monitor: compare due items 2 ns after each rising edge
    always begin
        @(posedge clk);
        cyc++;
        #2;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            act = (it.kind == 0) ? host_rdata : (it.kind == 1) ? mcu_rdata : {7'd0, mcu_irq};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h at cycle %0d",
                         it.tag, it.kind, act, it.exp, cyc);
            end
        end
    end

    task automatic push(int kind, logic [7:0] exp, string tag);
        item_t it;
        it.due = cyc + 1;
        it.kind = kind;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    // One clock of stimulus on both ports
    task automatic op(input logic hw, input logic hr, input logic [1:0] ha, input logic [7:0] hd,
                      input logic mw, input logic mr, input logic ma, input logic [7:0] md,
                      input logic clr, input string tag);
        logic [7:0] ns;
        @(negedge clk);
        host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hd;
        mcu_wr = mw; mcu_rd = mr; mcu_addr = ma; mcu_wdata = md;
        mcu_irq_clr = clr;
        // read values come from state before this cycle's writes
        if (hr) m_hrd = (ha == 2'd1) ? m_stat : (ha == 2'd3) ? m_en2 : 8'h00;
        if (mr) m_mrd = ma ? m_en2 : m_stat;
        ns = m_stat;
        if (mw && !ma) ns = md;
        if (hw && ha == 2'd1) ns = ns & ~hd;
        m_stat = ns & 8'h8F;
        if (hw && ha == 2'd3) m_en2 = hd & 8'h07;
        else if (mw && ma) m_en2 = md & 8'h07;
        if (hw && ha == 2'd1) m_irq = 1'b1;
        else if (clr) m_irq = 1'b0;
        push(0, m_hrd, tag);
        push(1, m_mrd, tag);
        push(2, {7'd0, m_irq}, tag);
    endtask

    task automatic idle(string tag);
        op(0, 0, 2'd0, 8'h00, 0, 0, 1'b0, 8'h00, 0, tag);
    endtask

    task automatic hread(logic [1:0] a, string tag);
        op(0, 1, a, 8'h00, 0, 0, 1'b0, 8'h00, 0, tag);
    endtask

    task automatic mread(logic a, string tag);
        op(0, 0, 2'd0, 8'h00, 0, 1, a, 8'h00, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        host_wr = 0; host_rd = 0; mcu_wr = 0; mcu_rd = 0; mcu_irq_clr = 0;
        m_stat = '0; m_en2 = '0; m_irq = 1'b0; m_hrd = '0; m_mrd = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: everything zero after reset
        hread(2'd1, "R10");
        mread(1'b1, "R10");
        idle("R10");
        // R3, R1, R2: direct load, reserved bits dropped
        op(0, 0, 2'd0, 8'h00, 1, 0, 1'b0, 8'hFF, 0, "R3");
        hread(2'd1, "R2");
        mread(1'b0, "R1");
        op(0, 0, 2'd0, 8'h00, 1, 0, 1'b0, 8'h05, 0, "R3");
        mread(1'b0, "R3");
        op(0, 0, 2'd0, 8'h00, 1, 0, 1'b0, 8'h70, 0, "R2");
        hread(2'd1, "R2");
        op(0, 0, 2'd0, 8'h00, 1, 0, 1'b0, 8'h8A, 0, "R3");
        hread(2'd1, "R1");
        // R4, R5: clear on one, keep on zero, interrupt raised
        op(1, 0, 2'd1, 8'h02, 0, 0, 1'b0, 8'h00, 0, "R4");
        hread(2'd1, "R4");
        op(1, 0, 2'd1, 8'h00, 0, 0, 1'b0, 8'h00, 0, "R5");
        mread(1'b0, "R4");
        // R6: hold, clear, set beats clear
        idle("R6");
        op(0, 0, 2'd0, 8'h00, 0, 0, 1'b0, 8'h00, 1, "R6");
        idle("R6");
        op(1, 0, 2'd1, 8'h80, 0, 0, 1'b0, 8'h00, 1, "R6");
        idle("R6");
        op(0, 0, 2'd0, 8'h00, 0, 0, 1'b0, 8'h00, 1, "R6");
        // R9: simultaneous writes
        op(1, 0, 2'd1, 8'h81, 1, 0, 1'b0, 8'h8F, 0, "R9");
        mread(1'b0, "R9");
        // R7: reserved enable register and offset 0
        op(0, 0, 2'd0, 8'h00, 0, 0, 1'b0, 8'h00, 1, "R7");
        op(1, 0, 2'd2, 8'hFF, 0, 0, 1'b0, 8'h00, 0, "R7");
        op(1, 0, 2'd0, 8'hFF, 0, 0, 1'b0, 8'h00, 0, "R7");
        hread(2'd2, "R7");
        hread(2'd0, "R7");
        mread(1'b0, "R7");
        // R8: second enable register from both ports
        op(1, 0, 2'd3, 8'hFF, 0, 0, 1'b0, 8'h00, 0, "R8");
        mread(1'b1, "R8");
        op(0, 0, 2'd0, 8'h00, 1, 0, 1'b1, 8'h02, 0, "R8");
        hread(2'd3, "R8");
        op(1, 0, 2'd3, 8'h05, 1, 0, 1'b1, 8'h03, 0, "R8");
        mread(1'b1, "R8");
        // R11: read in a write cycle returns old value; data holds between reads
        op(1, 1, 2'd3, 8'h01, 0, 0, 1'b0, 8'h00, 0, "R11");
        op(0, 0, 2'd0, 8'h00, 1, 0, 1'b1, 8'h06, 0, "R11");
        idle("R11");
        hread(2'd3, "R11");
        // R10: reset in mid-run
        op(0, 0, 2'd0, 8'h00, 1, 0, 1'b0, 8'h8F, 0, "R10");
        op(1, 0, 2'd1, 8'h00, 0, 0, 1'b0, 8'h00, 0, "R10");
        do_reset();
        idle("R10");
        hread(2'd1, "R10");
        mread(1'b1, "R10");
        repeat (3) idle("R10");
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule